// File: doc/BRIEF.md
# Per-queue credit-based egress shaper

This block decides which transmit queue of one switch egress port gets the next transmission opportunity. Each queue is either unshaped or held back by a signed credit account. Software selects a queue through an index register. After that, the control, watermark and increment registers it reads and writes belong to that queue. A port-level split field sets how many of the queues are in use.

Credit is counted in byte times as a fixed-point number with INC_W fractional bits. On each byte tick, a queue that is sending loses (1 - increment). A queue that is waiting but not sending gains the increment. An idle queue holding positive credit drops to zero. A shaped queue may win only when its credit is zero or more. Among the eligible queues, the highest-numbered one wins. The grant comes out one cycle after the transmission opportunity that asked for it.

Top module: `cbs_shaper`

## Requirements
- R1: After reset:
  - the queue index reads 0;
  - every queue's control byte reads 0x80 (weighted round-robin scheduling, shaping off);
  - watermarks and increments read 0;
  - the split field reads 3 when NUM_Q is 8 and 2 when NUM_Q is 4;
  - grant_valid_o is low.
- R2: Writing address 0 (queue index) with a value below NUM_Q selects that queue. A value of NUM_Q or more is ignored and the previous selection stays.
- R3: Addresses 1 (control, 8 bits), 2 (high watermark, 16 bits), 3 (low watermark, 16 bits) and 4 (increment) each hold one value per queue. Reads and writes go to the selected queue only. The control byte holds the scheduling mode in bits [7:6] and the shaping mode in bits [5:4]. Only shaping mode 1 enables credit shaping. Enabling shaping is a write of 0x10; disabling it is a write of 0x80.
- R4: The increment is INC_W bits wide (24 by default, 16 in the four-queue variant). Higher written bits are dropped and read back as zero.
- R5: Address 5 holds the 2-bit split field, which sets the active queue count: 0 gives one queue, 1 gives two, 2 gives four, 3 gives eight. A queue at or above that count is never granted.
- R6: On a byte tick, a shaped queue that requests and is not sending gains the increment. Its credit saturates at the high watermark, counted in whole bytes.
- R7: On a byte tick, the shaped queue named by tx_queue_i while tx_active_i is high loses (1 - increment). Its credit saturates at minus the low watermark.
- R8: On a byte tick, a shaped queue that neither requests nor sends and holds positive credit resets to zero. A queue with shaping off holds zero credit.
- R9: A queue is eligible when it requests and is active, and it is either unshaped or its credit is zero or more.
- R10: A cycle with tx_opp_i high makes grant_valid_o high in the next cycle if any queue is eligible. grant_q_o then names the highest-numbered eligible queue. With no opportunity, grant_valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address (0 index, 1 control, 2 high, 3 low, 4 increment, 5 split) |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| req_i | input | NUM_Q | Frame waiting, one bit per queue |
| byte_tick_i | input | 1 | One byte time has elapsed |
| tx_active_i | input | 1 | A byte of tx_queue_i is on the wire this byte time |
| tx_queue_i | input | $clog2(NUM_Q) | Queue currently sending |
| tx_opp_i | input | 1 | Transmission opportunity |
| grant_valid_o | output | 1 | Grant issued |
| grant_q_o | output | $clog2(NUM_Q) | Granted queue |

## Verification
The hardest situations to reach are the two credit saturation limits and the idle clear. Credit has no read port, so the only way to see it is whether a shaped queue is granted. The bench uses an increment of one quarter, which makes every credit value an exact multiple of 0.25. It drives the queue into a limit, then counts ticks until eligibility flips, and checks that the flip happens on exactly the tick that the saturated value predicts. An unsaturated value would flip the result on that same tick. The idle clear is shown the same way: the queue builds up credit, drops its request for one tick, and then sends one byte. The queue is granted after that byte only if the clear did not happen.

// File: rtl/cbs_pkg.sv
package cbs_pkg;
  typedef enum logic [2:0] {
    A_INDEX = 3'd0,
    A_CTRL  = 3'd1,
    A_HIGH  = 3'd2,
    A_LOW   = 3'd3,
    A_INCR  = 3'd4,
    A_SPLIT = 3'd5
  } reg_addr_e;

  localparam logic [1:0] SHAPE_OFF    = 2'd0;
  localparam logic [1:0] SHAPE_CREDIT = 2'd1;
  localparam logic [7:0] CTRL_RESET   = 8'h80;

  function automatic logic [3:0] split_count(input logic [1:0] s);
    return 4'd1 << s;
  endfunction
endpackage

// File: rtl/cbs_regs.sv
module cbs_regs import cbs_pkg::*; #(
  parameter int NUM_Q = 8,
  parameter int INC_W = 24,
  localparam int QW = $clog2(NUM_Q)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [2:0]                  addr_i,
  input  logic [31:0]                 wdata_i,
  output logic [31:0]                 rdata_o,
  output logic [QW-1:0]               sel_o,
  output logic [1:0]                  split_o,
  output logic [NUM_Q-1:0][7:0]       ctrl_o,
  output logic [NUM_Q-1:0][15:0]      high_o,
  output logic [NUM_Q-1:0][15:0]      low_o,
  output logic [NUM_Q-1:0][INC_W-1:0] incr_o
);
  localparam logic [1:0] SPLIT_RST = (NUM_Q >= 8) ? 2'd3 : 2'd2;

  logic [QW-1:0] sel_q;
  logic [1:0]    split_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= '0;
      split_q <= SPLIT_RST;
    end else if (we_i) begin
      if (addr_i == A_INDEX && wdata_i < 32'(NUM_Q)) sel_q <= wdata_i[QW-1:0];
      if (addr_i == A_SPLIT) split_q <= wdata_i[1:0];
    end
  end

  for (genvar q = 0; q < NUM_Q; q++) begin : g_q
    logic hit;
    assign hit = we_i && (sel_q == QW'(q));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ctrl_o[q] <= CTRL_RESET;
        high_o[q] <= '0;
        low_o[q]  <= '0;
        incr_o[q] <= '0;
      end else if (hit) begin
        case (addr_i)
          A_CTRL: ctrl_o[q] <= wdata_i[7:0];
          A_HIGH: high_o[q] <= wdata_i[15:0];
          A_LOW:  low_o[q]  <= wdata_i[15:0];
          A_INCR: incr_o[q] <= wdata_i[INC_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr_i)
      A_INDEX: rdata_o = 32'(sel_q);
      A_CTRL:  rdata_o = 32'(ctrl_o[sel_q]);
      A_HIGH:  rdata_o = 32'(high_o[sel_q]);
      A_LOW:   rdata_o = 32'(low_o[sel_q]);
      A_INCR:  rdata_o = 32'(incr_o[sel_q]);
      A_SPLIT: rdata_o = 32'(split_q);
      default: rdata_o = '0;
    endcase
  end

  assign sel_o   = sel_q;
  assign split_o = split_q;
endmodule

// File: rtl/cbs_credit.sv
module cbs_credit #(
  parameter int INC_W = 24,
  localparam int CW = 16 + INC_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shaped_i,
  input  logic             tick_i,
  input  logic             waiting_i,
  input  logic             sending_i,
  input  logic [15:0]      high_i,
  input  logic [15:0]      low_i,
  input  logic [INC_W-1:0] incr_i,
  output logic             nonneg_o
);
  localparam logic signed [CW-1:0] ONE = {{(CW-INC_W-1){1'b0}}, 1'b1, {INC_W{1'b0}}};

  logic signed [CW-1:0] credit_q, credit_d;
  logic signed [CW-1:0] ceil_v, floor_v, up_v, dn_v, step_up;

  assign ceil_v  = $signed({2'b00, high_i, {INC_W{1'b0}}});
  assign floor_v = -$signed({2'b00, low_i, {INC_W{1'b0}}});
  assign step_up = $signed({{(CW-INC_W){1'b0}}, incr_i});
  assign up_v    = credit_q + step_up;
  assign dn_v    = credit_q - (ONE - step_up);

  always_comb begin
    credit_d = credit_q;
    if (!shaped_i) begin
      credit_d = '0;
    end else if (tick_i) begin
      if (sending_i)        credit_d = (dn_v < floor_v) ? floor_v : dn_v;
      else if (waiting_i)   credit_d = (up_v > ceil_v) ? ceil_v : up_v;
      else if (credit_q > 0) credit_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) credit_q <= '0;
    else         credit_q <= credit_d;
  end

  assign nonneg_o = !credit_q[CW-1];
endmodule

// File: rtl/cbs_arb.sv
module cbs_arb #(
  parameter int NUM_Q = 8,
  localparam int QW = $clog2(NUM_Q)
) (
  input  logic [NUM_Q-1:0] elig_i,
  output logic             any_o,
  output logic [QW-1:0]    win_o
);
  always_comb begin
    any_o = 1'b0;
    win_o = '0;
    for (int q = 0; q < NUM_Q; q++) begin
      if (elig_i[q]) begin
        any_o = 1'b1;
        win_o = QW'(q);
      end
    end
  end
endmodule

// File: rtl/cbs_shaper.sv
module cbs_shaper import cbs_pkg::*; #(
  parameter int NUM_Q = 8,
  parameter int INC_W = (NUM_Q >= 8) ? 24 : 16,
  localparam int QW = $clog2(NUM_Q)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [2:0]       reg_addr_i,
  input  logic [31:0]      reg_wdata_i,
  output logic [31:0]      reg_rdata_o,
  input  logic [NUM_Q-1:0] req_i,
  input  logic             byte_tick_i,
  input  logic             tx_active_i,
  input  logic [QW-1:0]    tx_queue_i,
  input  logic             tx_opp_i,
  output logic             grant_valid_o,
  output logic [QW-1:0]    grant_q_o
);
  logic [QW-1:0]                  sel_q;
  logic [1:0]                     split_q;
  logic [NUM_Q-1:0][7:0]          ctrl;
  logic [NUM_Q-1:0][15:0]         high, low;
  logic [NUM_Q-1:0][INC_W-1:0]    incr;
  logic [NUM_Q-1:0]               nonneg, shaped, active, elig;
  logic [3:0]                     act_cnt;
  logic                           any_elig;
  logic [QW-1:0]                  win;

  cbs_regs #(.NUM_Q(NUM_Q), .INC_W(INC_W)) i_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .sel_o(sel_q), .split_o(split_q),
    .ctrl_o(ctrl), .high_o(high), .low_o(low), .incr_o(incr)
  );

  assign act_cnt = split_count(split_q);

  for (genvar q = 0; q < NUM_Q; q++) begin : g_q
    assign shaped[q] = ctrl[q][5:4] == SHAPE_CREDIT;
    assign active[q] = q < int'(act_cnt);
    cbs_credit #(.INC_W(INC_W)) i_credit (
      .clk_i, .rst_ni,
      .shaped_i(shaped[q]),
      .tick_i(byte_tick_i),
      .waiting_i(req_i[q]),
      .sending_i(tx_active_i && tx_queue_i == QW'(q)),
      .high_i(high[q]), .low_i(low[q]), .incr_i(incr[q]),
      .nonneg_o(nonneg[q])
    );
    assign elig[q] = req_i[q] && active[q] && (!shaped[q] || nonneg[q]);
  end

  cbs_arb #(.NUM_Q(NUM_Q)) i_arb (.elig_i(elig), .any_o(any_elig), .win_o(win));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_valid_o <= 1'b0;
      grant_q_o     <= '0;
    end else begin
      grant_valid_o <= tx_opp_i && any_elig;
      if (tx_opp_i && any_elig) grant_q_o <= win;
    end
  end
endmodule

// File: rtl/cbs_shaper_chk.sv
module cbs_shaper_chk #(
  parameter int NUM_Q = 8,
  localparam int QW = $clog2(NUM_Q)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_we_i,
  input logic [2:0]       reg_addr_i,
  input logic [31:0]      reg_wdata_i,
  input logic [NUM_Q-1:0] req_i,
  input logic             tx_opp_i,
  input logic             grant_valid_o,
  input logic [QW-1:0]    grant_q_o,
  input logic [QW-1:0]    sel_q,
  input logic [1:0]       split_q
);
  logic [NUM_Q-1:0] req_d;
  logic [1:0]       split_d;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_d   <= '0;
      split_d <= '0;
    end else begin
      req_d   <= req_i;
      split_d <= split_q;
    end
  end

  assert_grant_after_opp_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_o |-> $past(tx_opp_i));
  assert_no_req_no_grant_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_opp_i && req_i == '0) |=> !grant_valid_o);
  assert_grant_requested_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_o |-> req_d[grant_q_o]);
  assert_index_reject_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 3'd0 && reg_wdata_i >= 32'(NUM_Q)) |=> $stable(sel_q));
  assert_active_only_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_o |-> (32'(grant_q_o) < (32'd1 << split_d)));
endmodule

bind cbs_shaper cbs_shaper_chk #(.NUM_Q(NUM_Q)) i_chk (
  .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .req_i, .tx_opp_i,
  .grant_valid_o, .grant_q_o, .sel_q(sel_q), .split_q(split_q)
);

// File: tb/test_cbs_shaper.sv
module test_cbs_shaper;
  localparam int NUM_Q = 8;
  localparam int QW = 3;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic reg_we_i = 1'b0;
  logic [2:0] reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0, reg_rdata_o;
  logic [NUM_Q-1:0] req_i = '0;
  logic byte_tick_i = 1'b0, tx_active_i = 1'b0, tx_opp_i = 1'b0;
  logic [QW-1:0] tx_queue_i = '0, grant_q_o;
  logic grant_valid_o;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  cbs_shaper #(.NUM_Q(NUM_Q)) i_cbs_shaper (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk_i); reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i); reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk_i); reg_addr_i = a; #1;
    chk(tag, reg_rdata_o, exp);
  endtask

  task automatic opp(input bit ev, input int eq, input string tag);
    @(negedge clk_i); tx_opp_i = 1'b1;
    @(negedge clk_i); tx_opp_i = 1'b0;
    chk(tag, {31'd0, grant_valid_o}, {31'd0, ev});
    if (ev) chk(tag, 32'(grant_q_o), 32'(eq));
  endtask

  task automatic tick(input int n, input bit send, input logic [QW-1:0] q);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); byte_tick_i = 1'b1; tx_active_i = send; tx_queue_i = q;
      @(negedge clk_i); byte_tick_i = 1'b0; tx_active_i = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    chk("R1 grant", {31'd0, grant_valid_o}, 32'd0);
    rd(3'd0, 32'd0, "R1 index");
    rd(3'd5, 32'd3, "R1 split");
    for (int q = 0; q < NUM_Q; q++) begin
      wr(3'd0, q);
      rd(3'd1, 32'h80, "R1 ctrl");
      rd(3'd2, 32'd0, "R1 high");
      rd(3'd4, 32'd0, "R1 incr");
    end
    // R2 index rejection
    wr(3'd0, 32'd5);
    wr(3'd0, 32'd8);
    rd(3'd0, 32'd5, "R2 reject 8");
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, 32'd5, "R2 reject big");
    wr(3'd0, 32'd7);
    rd(3'd0, 32'd7, "R2 accept 7");
    // R3 per-queue storage sweep
    for (int q = 0; q < NUM_Q; q++) begin
      wr(3'd0, q);
      wr(3'd1, 32'h80 | q);
      wr(3'd2, 32'h1000 + q * 32'h111);
      wr(3'd3, 32'h2000 + q * 32'h21);
      wr(3'd4, 32'h30000 + q * 32'h1357);
    end
    for (int q = 0; q < NUM_Q; q++) begin
      wr(3'd0, q);
      rd(3'd1, 32'h80 | q, "R3 ctrl");
      rd(3'd2, 32'h1000 + q * 32'h111, "R3 high");
      rd(3'd3, 32'h2000 + q * 32'h21, "R3 low");
      rd(3'd4, 32'h30000 + q * 32'h1357, "R3 incr");
    end
    // R4 increment width
    wr(3'd0, 32'd0);
    wr(3'd4, 32'hFFFF_FFFF);
    rd(3'd4, 32'h00FF_FFFF, "R4 incr width");
    wr(3'd2, 32'hABCD_1234);
    rd(3'd2, 32'h0000_1234, "R3 high width");
    // R10 unshaped sweep of every request pattern
    for (int p = 0; p < 256; p++) begin
      int e = -1;
      for (int b = 0; b < 8; b++) if (p[b]) e = b;
      req_i = p[7:0];
      opp(e >= 0, e, "R10 priority");
    end
    req_i = 8'hFF;
    @(negedge clk_i);
    chk("R10 no opp", {31'd0, grant_valid_o}, 32'd0);
    // R5 split
    wr(3'd5, 32'd0); opp(1, 0, "R5 split0");
    wr(3'd5, 32'd1); opp(1, 1, "R5 split1");
    wr(3'd5, 32'd2); opp(1, 3, "R5 split2");
    wr(3'd5, 32'd3); opp(1, 7, "R5 split3");
    rd(3'd5, 32'd3, "R5 readback");
    // shaping on queue 7: increment 1/4, high 2, low 3
    wr(3'd0, 32'd7);
    wr(3'd2, 32'd2);
    wr(3'd3, 32'd3);
    wr(3'd4, 32'h40_0000);
    wr(3'd1, 32'h10);
    rd(3'd1, 32'h10, "R3 enable ctrl");
    req_i = 8'h80;
    opp(1, 7, "R9 zero credit eligible");
    tick(1, 1, 3'd7);                       // -0.75
    opp(0, 0, "R7 after send");
    req_i = 8'h88;
    opp(1, 3, "R9 unshaped passes");
    req_i = 8'h80;
    tick(2, 0, 3'd0);                       // -0.25
    opp(0, 0, "R6 still negative");
    tick(1, 0, 3'd0);                       // 0
    opp(1, 7, "R6 reaches zero");
    tick(20, 0, 3'd0);                      // saturate at 2
    tick(2, 1, 3'd7);                       // 0.5
    opp(1, 7, "R6 high clamp");
    tick(1, 1, 3'd7);                       // -0.25
    opp(0, 0, "R6 high clamp edge");
    tick(10, 1, 3'd7);                      // clamp -3
    tick(11, 0, 3'd0);                      // -0.25
    opp(0, 0, "R7 low clamp");
    tick(1, 0, 3'd0);                       // 0
    opp(1, 7, "R7 low clamp edge");
    tick(4, 0, 3'd0);                       // 1.0
    req_i = 8'h00;
    tick(1, 0, 3'd0);                       // idle clear to 0
    req_i = 8'h80;
    tick(1, 1, 3'd7);                       // -0.75
    opp(0, 0, "R8 idle clear");
    wr(3'd1, 32'h80);
    opp(1, 7, "R8 shaping off clears");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule